// File: doc/BRIEF.md
# Transition-Coded Multi-Wire Line Encoder

This block converts a byte message into a self-timed series of states on a small group of parallel wires (2 to 4, set by `NWIRES`). Every symbol must change the bus state. A symbol therefore selects one of `R = 2^NWIRES - 1` non-zero XOR masks and carries one base-R digit. Payload bits are gathered into 11-bit chunks. Each chunk is sent as a fixed number of digits: 7 for two wires, 4 for three and 3 for four. Chunk values from 2048 upward cannot be data, so they are free to carry control information in band.

A frame opens with one transition whose digit gives the message priority. The data chunks follow, then one chunk holding an 11-bit CRC of the transmitted chunk values. The frame closes with an out-of-band chunk that states how many bits of the last data chunk are valid. Transitions advance only on the `step` strobe, which sets the line rate.

Bytes enter through a valid/ready port. A byte moves only in a cycle where both `in_valid` and `in_ready` are high. `in_ready` is held low while a frame is idle, while the priority transition or any chunk is being shifted out, and during the CRC and closing phases. The source may insert bubbles. It must present `prio` together with the first byte, and it marks the final byte with `in_last`.

Top module: `lw_line_encoder`

## Requirements
- R1: After reset `bus_state` is 0 and `in_ready` is 0.
- R2: Each transition XORs `bus_state` with (digit+1), where the digit lies in 0..R-1, so every transition changes the state.
- R3: When `in_valid` rises in an idle frame, the first transition carries digit `prio`. The all-ones value of `prio` is saturated to R-1.
- R4: Bytes are packed MSB first into 11-bit chunks. Each chunk is emitted as D base-R digits, most significant first, with D = 7, 4, 3 for 2, 3, 4 wires.
- R5: A final chunk with fewer than 11 payload bits holds them left-aligned and zero-filled below.
- R6: After the data comes one chunk holding a CRC-11. The CRC uses polynomial 0x385 (x^11+x^9+x^8+x^7+x^2+1) and starts at 0. It is shifted MSB first over the 11-bit value of every data chunk of the frame.
- R7: The last chunk of a frame has the value 2048 + n, where n (1..11) is the number of valid bits in the final data chunk.
- R8: Exactly one transition happens per `step` pulse while symbols are pending. A `step` with nothing pending leaves `bus_state` unchanged.
- R9: `in_ready` is high only in the data phase while no chunk or priority symbol is in flight. A byte is taken only when `in_valid` and `in_ready` are both high.
- R10: After the closing chunk the bus holds its state, and the next frame begins when `in_valid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte accepted this cycle when valid is also high |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | Marks the final byte of the message |
| prio | input | NWIRES | Frame priority digit, sampled at frame start |
| step | input | 1 | Line-rate strobe, one transition per pulse |
| bus_state | output | NWIRES | Current wire-group state |

## Verification
Two events can share a cycle: a `step` pulse and the loading of the next chunk into the digit shifter after the previous chunk's final digit. The loading cycle must swallow that pulse without a transition. The bench holds `step` high on every cycle in one frame to force this case. In other frames it uses a sparse pattern and a random one. A scoreboard built from the requirements lists every expected bus state, so any extra, missing or early transition shows up as a mismatch. A monitor also checks that `in_ready` rises only on chunk boundaries inside the data phase.

// File: rtl/lw_enc_pkg.sv
package lw_enc_pkg;

  localparam int unsigned CHUNK_W  = 11;
  localparam int unsigned CODE_W   = 12;
  localparam int unsigned BYTE_W   = 8;
  localparam logic [CHUNK_W-1:0] CRC_POLY = 11'h385;
  localparam logic [CODE_W-1:0]  OOB_BASE = 12'd2048;
  // Largest code ever sent: out-of-band base plus a full chunk count.
  localparam int unsigned CODE_MAX = 2048 + 11;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DATA,
    PH_CRC,
    PH_TERM,
    PH_DRAIN
  } phase_e;

  function automatic int unsigned radix_of(input int unsigned nw);
    return (1 << nw) - 1;
  endfunction

  function automatic int unsigned power_of(input int unsigned b, input int unsigned e);
    int unsigned p;
    p = 1;
    for (int unsigned i = 0; i < e; i++) p = p * b;
    return p;
  endfunction

  // Fewest base-r digits able to express every code up to CODE_MAX.
  function automatic int unsigned digits_of(input int unsigned nw);
    int unsigned r, p, d;
    r = radix_of(nw);
    p = 1;
    d = 0;
    for (int i = 0; i < 16; i++) begin
      if (p <= CODE_MAX) begin
        p = p * r;
        d = d + 1;
      end
    end
    return d;
  endfunction

  // Shift one whole chunk, MSB first, through the CRC register.
  function automatic logic [CHUNK_W-1:0] crc_chunk(input logic [CHUNK_W-1:0] crc_in,
                                                   input logic [CHUNK_W-1:0] chunk);
    logic [CHUNK_W-1:0] c;
    logic fb;
    c = crc_in;
    for (int b = CHUNK_W - 1; b >= 0; b--) begin
      fb = c[CHUNK_W-1] ^ chunk[b];
      c  = {c[CHUNK_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/lw_chunk_pack.sv
module lw_chunk_pack
  import lw_enc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BYTE_W-1:0]  in_data,
  input  logic               in_last,
  output logic               ck_valid,
  input  logic               ck_pop,
  output logic [CHUNK_W-1:0] ck_data,
  output logic               ck_last,
  output logic [3:0]         ck_nbits
);

  localparam int unsigned ACC_W = CHUNK_W + BYTE_W - 1;
  localparam int unsigned CNT_W = $clog2(ACC_W + 1);
  localparam logic [CNT_W-1:0] CH = CNT_W'(CHUNK_W);

  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flush_q;
  logic             full;
  logic             take;
  logic [ACC_W-1:0] shr;
  logic [ACC_W-1:0] shl;

  assign full     = (cnt_q >= CH);
  assign in_ready = en && !flush_q && !full;
  assign take     = in_valid && in_ready;
  assign ck_valid = en && (full || (flush_q && cnt_q != '0));
  assign ck_last  = flush_q && (cnt_q <= CH);
  assign ck_nbits = full ? 4'(CHUNK_W) : 4'(cnt_q);

  always_comb begin
    shr     = acc_q >> (cnt_q - CH);
    shl     = acc_q << (CH - cnt_q);
    ck_data = full ? shr[CHUNK_W-1:0] : shl[CHUNK_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      flush_q <= 1'b0;
    end else if (take) begin
      acc_q <= {acc_q[ACC_W-BYTE_W-1:0], in_data};
      cnt_q <= cnt_q + CNT_W'(BYTE_W);
      if (in_last) flush_q <= 1'b1;
    end else if (ck_pop && ck_valid) begin
      if (ck_last) begin
        cnt_q   <= '0;
        flush_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CH;
      end
    end
  end

  // Bit store never holds more than a partial chunk plus one byte.
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ACC_W));

endmodule

// File: rtl/lw_digit_ser.sv
module lw_digit_ser
  import lw_enc_pkg::*;
#(
  parameter int unsigned NW     = 2,
  parameter int unsigned RADIX  = 3,
  parameter int unsigned DIGITS = 7,
  parameter int unsigned CNT_W  = 3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] load_code,
  input  logic [CNT_W-1:0]  load_ndig,
  input  logic              step,
  output logic              busy,
  output logic [NW-1:0]     bus_state
);

  localparam int unsigned PROD_W = CODE_W + NW + 1;

  logic [CODE_W-1:0] wt [DIGITS];
  for (genvar k = 0; k < DIGITS; k++) begin : g_wt
    assign wt[k] = CODE_W'(power_of(RADIX, k));
  end

  logic [CODE_W-1:0] rem_q;
  logic [CNT_W-1:0]  left_q;
  logic [NW-1:0]     bus_q;
  logic [CNT_W-1:0]  widx;
  logic [PROD_W-1:0] rem_x;
  logic [PROD_W-1:0] w_x;
  logic [PROD_W-1:0] dig_prod;
  logic [NW-1:0]     dig;
  logic              fire;

  assign busy      = (left_q != '0);
  assign bus_state = bus_q;
  assign fire      = step && busy;
  assign widx      = busy ? (left_q - CNT_W'(1)) : '0;

  // Digit by comparison against multiples of the current weight.
  always_comb begin
    w_x   = PROD_W'(wt[widx]);
    rem_x = PROD_W'(rem_q);
    dig   = '0;
    for (int d = 1; d < RADIX; d++) begin
      if (rem_x >= PROD_W'(d) * w_x) dig = NW'(d);
    end
    dig_prod = PROD_W'(dig) * w_x;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      left_q <= '0;
      bus_q  <= '0;
    end else if (load) begin
      rem_q  <= load_code;
      left_q <= load_ndig;
    end else if (fire) begin
      rem_q  <= rem_q - dig_prod[CODE_W-1:0];
      left_q <= left_q - CNT_W'(1);
      bus_q  <= bus_q ^ (dig + NW'(1));
    end
  end

  p_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !load) |=> (bus_q != $past(bus_q)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(bus_q));

  p_load_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

  always_comb begin
    if (rst_n && busy) begin
      p_digit_range_r2: assert (int'(dig) < int'(RADIX));
    end
  end

endmodule

// File: rtl/lw_line_encoder.sv
module lw_line_encoder
  import lw_enc_pkg::*;
#(
  parameter int unsigned NWIRES = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [NWIRES-1:0] prio,
  input  logic              step,
  output logic [NWIRES-1:0] bus_state
);

  localparam int unsigned RADIX  = radix_of(NWIRES);
  localparam int unsigned DIGITS = digits_of(NWIRES);
  localparam int unsigned CNT_W  = $clog2(DIGITS + 1);

  phase_e             state_q, state_d;
  logic [CHUNK_W-1:0] crc_q, crc_d;
  logic [3:0]         nbits_q, nbits_d;
  logic               ser_busy;
  logic               ld;
  logic [CODE_W-1:0]  ld_code;
  logic [CNT_W-1:0]   ld_ndig;
  logic               pk_en;
  logic               pk_pop;
  logic               ck_valid;
  logic [CHUNK_W-1:0] ck_data;
  logic               ck_last;
  logic [3:0]         ck_nbits;
  logic [NWIRES-1:0]  prio_sat;

  assign prio_sat = (prio == {NWIRES{1'b1}}) ? NWIRES'(RADIX - 1) : prio;
  assign pk_en    = (state_q == PH_DATA) && !ser_busy;

  lw_chunk_pack u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (pk_en),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .in_last  (in_last),
    .ck_valid (ck_valid),
    .ck_pop   (pk_pop),
    .ck_data  (ck_data),
    .ck_last  (ck_last),
    .ck_nbits (ck_nbits)
  );

  lw_digit_ser #(
    .NW     (NWIRES),
    .RADIX  (RADIX),
    .DIGITS (DIGITS),
    .CNT_W  (CNT_W)
  ) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ld),
    .load_code (ld_code),
    .load_ndig (ld_ndig),
    .step      (step),
    .busy      (ser_busy),
    .bus_state (bus_state)
  );

  always_comb begin
    state_d = state_q;
    crc_d   = crc_q;
    nbits_d = nbits_q;
    ld      = 1'b0;
    ld_code = '0;
    ld_ndig = CNT_W'(DIGITS);
    pk_pop  = 1'b0;
    unique case (state_q)
      PH_IDLE: if (in_valid && !ser_busy) begin
        ld      = 1'b1;
        ld_code = CODE_W'(prio_sat);
        ld_ndig = CNT_W'(1);
        state_d = PH_DATA;
      end
      PH_DATA: if (ck_valid) begin
        ld      = 1'b1;
        ld_code = CODE_W'(ck_data);
        pk_pop  = 1'b1;
        crc_d   = crc_chunk(crc_q, ck_data);
        if (ck_last) begin
          nbits_d = ck_nbits;
          state_d = PH_CRC;
        end
      end
      PH_CRC: if (!ser_busy) begin
        ld      = 1'b1;
        ld_code = CODE_W'(crc_q);
        state_d = PH_TERM;
      end
      PH_TERM: if (!ser_busy) begin
        ld      = 1'b1;
        ld_code = OOB_BASE + CODE_W'(nbits_q);
        state_d = PH_DRAIN;
      end
      PH_DRAIN: if (!ser_busy) begin
        crc_d   = '0;
        state_d = PH_IDLE;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      crc_q   <= '0;
      nbits_q <= '0;
    end else begin
      state_q <= state_d;
      crc_q   <= crc_d;
      nbits_q <= nbits_d;
    end
  end

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ser_busy |-> !in_ready);

  p_idle_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PH_DATA) |-> !in_ready);

  p_last_nbits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_TERM) |-> (nbits_q != 4'd0 && nbits_q <= 4'd11));

endmodule

// File: tb/lw_line_encoder_tb_top.sv
module lw_line_encoder_tb_top;

  localparam int NW = 2;

  function automatic int tb_radix(input int n);
    return (1 << n) - 1;
  endfunction
  function automatic int tb_digits(input int n);
    return (n == 2) ? 7 : (n == 3) ? 4 : 3;
  endfunction

  localparam int RADIX  = tb_radix(NW);
  localparam int DIGITS = tb_digits(NW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_data = '0;
  logic          in_last = 1'b0;
  logic [NW-1:0] prio = '0;
  logic          step = 1'b0;
  logic [NW-1:0] bus_state;

  lw_line_encoder #(.NWIRES(NW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .prio      (prio),
    .step      (step),
    .bus_state (bus_state)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int step_mode = 0;
  bit finished = 0;
  bit run_mon  = 0;

  logic [NW-1:0] exp_q[$];
  int            kind_q[$];
  logic [NW-1:0] model_bus = '0;
  logic [7:0]    msg[$];

  logic [NW-1:0] prev_bus = '0;
  int            t_since = 0;
  int            last_kind = 3;

  function automatic string tag_of(input int k);
    case (k)
      0: return "R3";
      1: return "R4/R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Watchdog: an expired run counts as one failed check.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: cycles=%0d expected completion before 150000", cyc);
      summary_and_end();
    end
  end

  // Step strobe generator
  always @(negedge clk) begin
    case (step_mode)
      0: step <= 1'b1;
      1: step <= (cyc % 3 == 0);
      default: step <= 1'($urandom_range(0, 1));
    endcase
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && run_mon) begin
      if (bus_state !== prev_bus) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R8: bus=%0d expected no transition (stay %0d)", bus_state, prev_bus);
        end else begin
          logic [NW-1:0] e;
          int k;
          e = exp_q.pop_front();
          k = kind_q.pop_front();
          if (bus_state !== e) begin
            fails++;
            $display("FAIL %s (R2): bus=%0d expected %0d", tag_of(k), bus_state, e);
          end
          t_since   = (k == 0) ? 1 : t_since + 1;
          last_kind = k;
        end
        prev_bus = bus_state;
      end
      if (in_ready) begin
        checks++;
        if (!(last_kind <= 1 && t_since >= 1 && ((t_since - 1) % DIGITS) == 0)) begin
          fails++;
          $display("FAIL R9: in_ready=1 expected 0 (phase kind %0d, transitions %0d)",
                   last_kind, t_since);
        end
      end
    end
  end

  task automatic push_digit(input int d, input int kind);
    model_bus = model_bus ^ NW'(d + 1);
    exp_q.push_back(model_bus);
    kind_q.push_back(kind);
  endtask

  task automatic push_code(input int v, input int kind);
    for (int k = DIGITS - 1; k >= 0; k--) begin
      int w;
      w = 1;
      for (int i = 0; i < k; i++) w = w * RADIX;
      push_digit((v / w) % RADIX, kind);
    end
  endtask

  // Expected frame from the requirements: start, data chunks, CRC, closing code.
  task automatic build_frame(input int p);
    int total, nch, nlast;
    logic [10:0] crc;
    int pd;
    pd = (p == (1 << NW) - 1) ? RADIX - 1 : p;
    push_digit(pd, 0);
    total = 8 * msg.size();
    nch   = (total + 10) / 11;
    crc   = '0;
    for (int c = 0; c < nch; c++) begin
      logic [10:0] v;
      v = '0;
      for (int b = 0; b < 11; b++) begin
        int pos;
        logic bitv;
        pos  = 11 * c + b;
        bitv = (pos < total) ? msg[pos / 8][7 - (pos % 8)] : 1'b0;
        v    = {v[9:0], bitv};
      end
      for (int b = 10; b >= 0; b--) begin
        logic fb;
        fb  = crc[10] ^ v[b];
        crc = {crc[9:0], 1'b0};
        if (fb) crc = crc ^ 11'h385;
      end
      push_code(int'(v), 1);
    end
    nlast = total - 11 * (nch - 1);
    push_code(int'(crc), 2);
    push_code(2048 + nlast, 3);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic last, input int gap);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    in_last  = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic run_frame(input int p, input int gap);
    build_frame(p);
    prio = NW'(p);
    for (int i = 0; i < msg.size(); i++) send_byte(msg[i], i == msg.size() - 1, gap);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (25) @(negedge clk);
    // R8/R10: with steps still arriving, the bus holds after the closing chunk.
    checks++;
    if (bus_state !== model_bus) begin
      fails++;
      $display("FAIL R10: bus=%0d expected %0d after frame", bus_state, model_bus);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (bus_state !== '0 || in_ready !== 1'b0) begin
      fails++;
      $display("FAIL R1: bus=%0d ready=%0b expected 0/0", bus_state, in_ready);
    end
    run_mon = 1;

    // Single byte: partial final chunk (R5), closing code 2048+8 (R7); step every cycle.
    step_mode = 0;
    msg = '{8'hA5};
    run_frame(1, 0);

    // Eleven bytes fill exactly eight chunks (R4, R7 n=11); all-ones prio saturates (R3).
    step_mode = 1;
    msg.delete();
    for (int i = 0; i < 11; i++) msg.push_back(8'(i * 37 + 1));
    run_frame(3, 0);

    // Three bytes with source bubbles and random steps (R9 back-pressure, R6).
    step_mode = 2;
    msg = '{8'h3C, 8'h00, 8'hC3};
    run_frame(0, 4);

    // All-ones payload gives the largest data chunk value 2047 (R4).
    step_mode = 0;
    msg = '{8'hFF, 8'hFF};
    run_frame(2, 1);

    // R8: long run of steps with nothing pending, bus unchanged.
    step_mode = 0;
    repeat (40) @(negedge clk);
    checks++;
    if (bus_state !== model_bus || exp_q.size() != 0) begin
      fails++;
      $display("FAIL R8: bus=%0d expected %0d, pending %0d expected 0",
               bus_state, model_bus, exp_q.size());
    end

    finished = 1;
    summary_and_end();
  end

endmodule